// File: doc/BRIEF.md
# Banked Pseudo-Dual-Port Memory

This block looks like a two-port read/write memory from the outside, but inside it uses several single-ported storage banks. Each port issues one request per cycle with a valid/ready handshake. A request carries a write flag, a word address and write data. A field of address bits, whose position is set by a parameter, selects one bank. The remaining address bits select a row inside that bank, so every bank holds an equal share of the words.

A crossbar steers each accepted request into its bank. A second crossbar returns read data to the port that asked for it, one cycle after acceptance. When both ports want the same bank in the same cycle, only one is served. Port 0 normally wins. Port 1 holds its request and retries, and it can never lose more than twice in a row. A saturating counter records how many conflict cycles occurred, so the choice of bank-select field can be judged. The counter can be cleared from an input.

Top module: `banked_dp_mem`

## Requirements
- R1: A request on a port is accepted at a rising clock edge where that port's valid and ready are both high. A port whose request is not accepted keeps it pending and retries.
- R2: The bank index is the address field `addr[SEL_LSB +: log2(NBANK)]`. The row is the address with that field removed, with the upper bits shifted down. Two valid requests to different banks are both accepted in the same cycle.
- R3: A conflict is a cycle in which both ports are valid and their bank indices are equal. In a conflict cycle exactly one of the two ready outputs is high.
- R4: In a conflict cycle, if port 1 did not lose a conflict in the cycle before, port 0 is granted and port 1's ready is low.
- R5: If port 1 lost conflicts in the two previous cycles, then in a third consecutive conflict port 1 is granted and port 0's ready is low.
- R6: An accepted read raises that port's rvalid for exactly the next cycle. An accepted write and a cycle with no accepted request leave rvalid low in the next cycle.
- R7: Read data returned to either port always equals what a flat, unbanked memory would hold after all earlier accepted writes, whatever the bank mapping.
- R8: When both ports write the same address in the same cycle, port 0's write lands first and port 1's write lands on its retry. A later read returns port 1's data.
- R9: The conflict counter rises by one after each conflict cycle and holds at its all-ones value instead of wrapping. It is unchanged after a cycle with no conflict.
- R10: When the clear input is high at a clock edge, the counter reads zero after that edge, even if the cycle was also a conflict.
- R11: While reset (active low, asynchronous) is asserted, both rvalid outputs are low and the counter reads zero. Port 1's loss history is also cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| p0_valid | input | 1 | Port 0 request valid |
| p0_ready | output | 1 | Port 0 request can be accepted this cycle |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | log2(DEPTH) | Port 0 word address |
| p0_wdata | input | DW | Port 0 write data |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p0_rdata | output | DW | Port 0 read data |
| p1_valid | input | 1 | Port 1 request valid |
| p1_ready | output | 1 | Port 1 request can be accepted this cycle |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | log2(DEPTH) | Port 1 word address |
| p1_wdata | input | DW | Port 1 write data |
| p1_rvalid | output | 1 | Port 1 read data valid |
| p1_rdata | output | DW | Port 1 read data |
| conflict_clr | input | 1 | Clear the conflict counter |
| conflict_count | output | CNT_W | Saturating count of conflict cycles |

## Verification
The main pattern reads every one of the 64×64 address pairs on the two ports at the same time. The bench predicts from address arithmetic whether each pair shares a bank. This separates a correct bank field from one that is off by a bit, and it separates a conflict that stalls from one that corrupts data. Filling memory with same-bank write pairs, then mixing writes with reads at scattered addresses, shows that the row mapping loses and aliases nothing. A run of back-to-back same-bank requests with port 1 held pending checks the exact grant pattern across three cycles. Simultaneous writes to one address fix the write order. Counter runs with a narrow counter reach saturation, and a clear raised during a conflict shows that the clear takes priority.

// File: rtl/bdpm_pkg.sv
package bdpm_pkg;

    // Consecutive conflict losses suffered by port 1.
    typedef enum logic [1:0] {
        LOSS_NONE = 2'd0,
        LOSS_ONE  = 2'd1,
        LOSS_TWO  = 2'd2
    } p1_loss_e;

endpackage

// File: rtl/bdpm_bank.sv
module bdpm_bank #(
    parameter int ROWS = 16,
    parameter int DW   = 16,
    parameter int RW   = 4
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [ROWS];
    logic [DW-1:0] rd_q;

    // Single port: one read or one write per cycle.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                store[row] <= wdata;
            end else begin
                rd_q <= store[row];
            end
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/bdpm_arb.sv
module bdpm_arb
    import bdpm_pkg::*;
#(
    parameter int BB = 2
) (
    input  logic          v0,
    input  logic          v1,
    input  logic [BB-1:0] bank0,
    input  logic [BB-1:0] bank1,
    input  p1_loss_e      loss_q,
    output logic          rdy0,
    output logic          rdy1,
    output logic          conflict,
    output p1_loss_e      loss_d
);

    logic p1_turn;

    always_comb begin
        conflict = v0 && v1 && (bank0 == bank1);
        p1_turn  = conflict && (loss_q == LOSS_TWO);
        rdy0     = !p1_turn;
        rdy1     = !(conflict && !p1_turn);
        loss_d   = LOSS_NONE;
        if (conflict && !p1_turn) begin
            loss_d = (loss_q == LOSS_NONE) ? LOSS_ONE : LOSS_TWO;
        end
    end

endmodule

// File: rtl/bdpm_rd_xbar.sv
module bdpm_rd_xbar #(
    parameter int NBANK = 4,
    parameter int DW    = 16,
    parameter int BB    = 2
) (
    input  logic [NBANK-1:0][DW-1:0] bank_rdata,
    input  logic [BB-1:0]            sel0,
    input  logic [BB-1:0]            sel1,
    output logic [DW-1:0]            rdata0,
    output logic [DW-1:0]            rdata1
);

    assign rdata0 = bank_rdata[sel0];
    assign rdata1 = bank_rdata[sel1];

endmodule

// File: rtl/banked_dp_mem.sv
module banked_dp_mem
    import bdpm_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int DW      = 16,
    parameter int NBANK   = 4,
    parameter int SEL_LSB = 1,
    parameter int CNT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     p0_valid,
    output logic                     p0_ready,
    input  logic                     p0_we,
    input  logic [$clog2(DEPTH)-1:0] p0_addr,
    input  logic [DW-1:0]            p0_wdata,
    output logic                     p0_rvalid,
    output logic [DW-1:0]            p0_rdata,
    input  logic                     p1_valid,
    output logic                     p1_ready,
    input  logic                     p1_we,
    input  logic [$clog2(DEPTH)-1:0] p1_addr,
    input  logic [DW-1:0]            p1_wdata,
    output logic                     p1_rvalid,
    output logic [DW-1:0]            p1_rdata,
    input  logic                     conflict_clr,
    output logic [CNT_W-1:0]         conflict_count
);

    localparam int AW   = $clog2(DEPTH);
    localparam int BB   = $clog2(NBANK);
    localparam int RW   = AW - BB;
    localparam int ROWS = DEPTH / NBANK;
    localparam logic [AW-1:0]    LO_MASK = {AW{1'b1}} >> (AW - SEL_LSB);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        p1_loss_e         loss;
        logic [CNT_W-1:0] cnt;
        logic             rv0;
        logic             rv1;
        logic [BB-1:0]    rb0;
        logic [BB-1:0]    rb1;
    } state_t;

    function automatic logic [BB-1:0] bank_of(input logic [AW-1:0] a);
        return a[SEL_LSB +: BB];
    endfunction

    function automatic logic [RW-1:0] row_of(input logic [AW-1:0] a);
        logic [AW-1:0] t;
        t = ((a >> (SEL_LSB + BB)) << SEL_LSB) | (a & LO_MASK);
        return t[RW-1:0];
    endfunction

    state_t s_d, s_q;

    logic [BB-1:0] bank0, bank1;
    logic [RW-1:0] row0, row1;
    logic          acc0, acc1, conflict;
    p1_loss_e      loss_nx;
    logic [NBANK-1:0][DW-1:0] bank_rdata;

    assign bank0 = bank_of(p0_addr);
    assign bank1 = bank_of(p1_addr);
    assign row0  = row_of(p0_addr);
    assign row1  = row_of(p1_addr);

    bdpm_arb #(.BB(BB)) u_arb (
        .v0       (p0_valid),
        .v1       (p1_valid),
        .bank0    (bank0),
        .bank1    (bank1),
        .loss_q   (s_q.loss),
        .rdy0     (p0_ready),
        .rdy1     (p1_ready),
        .conflict (conflict),
        .loss_d   (loss_nx)
    );

    assign acc0 = p0_valid && p0_ready;
    assign acc1 = p1_valid && p1_ready;

    // Per-bank request steering.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic          hit0, hit1;
        logic          b_we;
        logic [RW-1:0] b_row;
        logic [DW-1:0] b_wdata;

        assign hit0    = acc0 && (bank0 == BB'(b));
        assign hit1    = acc1 && (bank1 == BB'(b));
        assign b_we    = hit1 ? p1_we    : p0_we;
        assign b_row   = hit1 ? row1     : row0;
        assign b_wdata = hit1 ? p1_wdata : p0_wdata;

        bdpm_bank #(.ROWS(ROWS), .DW(DW), .RW(RW)) u_bank (
            .clk   (clk),
            .en    (hit0 || hit1),
            .we    (b_we),
            .row   (b_row),
            .wdata (b_wdata),
            .rdata (bank_rdata[b])
        );
    end

    bdpm_rd_xbar #(.NBANK(NBANK), .DW(DW), .BB(BB)) u_xbar (
        .bank_rdata (bank_rdata),
        .sel0       (s_q.rb0),
        .sel1       (s_q.rb1),
        .rdata0     (p0_rdata),
        .rdata1     (p1_rdata)
    );

    always_comb begin
        s_d      = s_q;
        s_d.loss = loss_nx;
        s_d.rv0  = acc0 && !p0_we;
        s_d.rv1  = acc1 && !p1_we;
        if (acc0) begin
            s_d.rb0 = bank0;
        end
        if (acc1) begin
            s_d.rb1 = bank1;
        end
        if (conflict_clr) begin
            s_d.cnt = '0;
        end else if (conflict && (s_q.cnt != CNT_MAX)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{loss: LOSS_NONE, cnt: '0, rv0: 1'b0, rv1: 1'b0, rb0: '0, rb1: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign p0_rvalid      = s_q.rv0;
    assign p1_rvalid      = s_q.rv1;
    assign conflict_count = s_q.cnt;

endmodule

// File: rtl/banked_dp_mem_chk.sv
module banked_dp_mem_chk #(
    parameter int AW      = 6,
    parameter int BB      = 2,
    parameter int SEL_LSB = 1,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             p0_valid,
    input logic             p0_ready,
    input logic             p0_we,
    input logic [AW-1:0]    p0_addr,
    input logic             p0_rvalid,
    input logic             p1_valid,
    input logic             p1_ready,
    input logic             p1_we,
    input logic [AW-1:0]    p1_addr,
    input logic             p1_rvalid,
    input logic             conflict_clr,
    input logic [CNT_W-1:0] conflict_count
);

    logic same_bank, clash, rd0, rd1;

    assign same_bank = (p0_addr[SEL_LSB +: BB] == p1_addr[SEL_LSB +: BB]);
    assign clash     = p0_valid && p1_valid && same_bank;
    assign rd0       = p0_valid && p0_ready && !p0_we;
    assign rd1       = p1_valid && p1_ready && !p1_we;

    p_parallel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_valid && p1_valid && !same_bank) |-> (p0_ready && p1_ready));

    p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> ($countones({p0_ready, p1_ready}) == 1));

    p_p0_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clash && !$past(clash && !p1_ready)) |-> (p0_ready && !p1_ready));

    p_no_starve_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clash && $past(clash && !p1_ready) && $past(clash && !p1_ready, 2))
        |-> (p1_ready && !p0_ready));

    p_rvalid0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd0 |=> p0_rvalid);

    p_rvalid0_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd0 |=> !p0_rvalid);

    p_rvalid1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd1 |=> p1_rvalid);

    p_rvalid1_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd1 |=> !p1_rvalid);

    p_count_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clash && !conflict_clr && (conflict_count != '1))
        |=> (conflict_count == CNT_W'($past(conflict_count) + 1'b1)));

    p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clash && !conflict_clr) |=> $stable(conflict_count));

    p_count_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_clr |=> (conflict_count == '0));

endmodule

bind banked_dp_mem banked_dp_mem_chk #(
    .AW(AW), .BB(BB), .SEL_LSB(SEL_LSB), .CNT_W(CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .p0_valid       (p0_valid),
    .p0_ready       (p0_ready),
    .p0_we          (p0_we),
    .p0_addr        (p0_addr),
    .p0_rvalid      (p0_rvalid),
    .p1_valid       (p1_valid),
    .p1_ready       (p1_ready),
    .p1_we          (p1_we),
    .p1_addr        (p1_addr),
    .p1_rvalid      (p1_rvalid),
    .conflict_clr   (conflict_clr),
    .conflict_count (conflict_count)
);

// File: tb/test_banked_dp_mem.sv
`timescale 1ns/1ps
module test_banked_dp_mem;

    localparam int NB  = 4;
    localparam int SEL = 1;
    localparam int CW  = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        p0_valid, p0_ready, p0_we, p0_rvalid;
    logic [5:0]  p0_addr;
    logic [15:0] p0_wdata, p0_rdata;
    logic        p1_valid, p1_ready, p1_we, p1_rvalid;
    logic [5:0]  p1_addr;
    logic [15:0] p1_wdata, p1_rdata;
    logic        conflict_clr;
    logic [CW-1:0] conflict_count;

    logic [15:0] model [64];
    int n_chk = 0;
    int n_fail = 0;
    int n_conf = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    banked_dp_mem #(.DEPTH(64), .DW(16), .NBANK(NB), .SEL_LSB(SEL), .CNT_W(CW)) i_banked_dp_mem (
        .clk(clk), .rst_n(rst_n),
        .p0_valid(p0_valid), .p0_ready(p0_ready), .p0_we(p0_we), .p0_addr(p0_addr),
        .p0_wdata(p0_wdata), .p0_rvalid(p0_rvalid), .p0_rdata(p0_rdata),
        .p1_valid(p1_valid), .p1_ready(p1_ready), .p1_we(p1_we), .p1_addr(p1_addr),
        .p1_wdata(p1_wdata), .p1_rvalid(p1_rvalid), .p1_rdata(p1_rdata),
        .conflict_clr(conflict_clr), .conflict_count(conflict_count)
    );

    function automatic int bnk(input logic [5:0] a);
        return (int'(a) >> SEL) % NB;
    endfunction

    function automatic logic [15:0] pat(input int a, input int ph);
        return 16'((a * 613 + ph * 4099 + 97) & 32'hFFFF);
    endfunction

    function automatic int sat(input int n);
        return (n > 15) ? 15 : n;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock cycle: drive at negedge, evaluate results at the following negedge.
    task automatic tick(input logic v0, input logic w0, input logic [5:0] a0, input logic [15:0] d0,
                        input logic v1, input logic w1, input logic [5:0] a1, input logic [15:0] d1,
                        output logic g0, output logic g1);
        logic ev0, ev1;
        logic [15:0] ed0, ed1;
        p0_valid = v0; p0_we = w0; p0_addr = a0; p0_wdata = d0;
        p1_valid = v1; p1_we = w1; p1_addr = a1; p1_wdata = d1;
        #1;
        g0 = v0 && p0_ready;
        g1 = v1 && p1_ready;
        if (v0 && v1 && bnk(a0) == bnk(a1)) n_conf++;
        ev0 = g0 && !w0; ed0 = model[a0];
        ev1 = g1 && !w1; ed1 = model[a1];
        if (g0 && w0) model[a0] = d0;
        if (g1 && w1) model[a1] = d1;
        @(negedge clk);
        check(p0_rvalid == ev0, "R6 p0_rvalid", int'(p0_rvalid), int'(ev0));
        check(p1_rvalid == ev1, "R6 p1_rvalid", int'(p1_rvalid), int'(ev1));
        if (ev0) check(p0_rdata == ed0, "R7 p0_rdata", int'(p0_rdata), int'(ed0));
        if (ev1) check(p1_rdata == ed1, "R7 p1_rdata", int'(p1_rdata), int'(ed1));
    endtask

    task automatic idle();
        logic g0, g1;
        tick(0, 0, 6'd0, 16'd0, 0, 0, 6'd0, 16'd0, g0, g1);
    endtask

    // Both ports issue one request; retry until both are accepted.
    task automatic pair(input logic w0, input logic [5:0] a0, input logic [15:0] d0,
                        input logic w1, input logic [5:0] a1, input logic [15:0] d1);
        logic g0, g1;
        bit done0 = 0, done1 = 0;
        int cyc = 0;
        bit same = (bnk(a0) == bnk(a1));
        while (!(done0 && done1) && cyc < 8) begin
            tick(!done0, w0, a0, d0, !done1, w1, a1, d1, g0, g1);
            if (cyc == 0) begin
                check(g0 == 1'b1, "R4 p0 first grant", int'(g0), 1);
                check(g1 == !same, "R2/R3 p1 first ready", int'(g1), int'(!same));
            end
            if (g0) done0 = 1;
            if (g1) done1 = 1;
            cyc++;
        end
        check(cyc == (same ? 2 : 1), "R1 cycles to accept both", cyc, same ? 2 : 1);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic g0, g1;
        int base;
        rst_n = 1'b0; conflict_clr = 1'b0;
        p0_valid = 0; p0_we = 0; p0_addr = '0; p0_wdata = '0;
        p1_valid = 0; p1_we = 0; p1_addr = '0; p1_wdata = '0;
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check(p0_rvalid == 1'b0, "R11 reset p0_rvalid", int'(p0_rvalid), 0);
        check(p1_rvalid == 1'b0, "R11 reset p1_rvalid", int'(p1_rvalid), 0);
        check(conflict_count == '0, "R11 reset counter", int'(conflict_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Fill: every pair shares a bank (a and a+32 differ above the bank field).
        for (int a = 0; a < 32; a++) pair(1, 6'(a), pat(a, 0), 1, 6'(a + 32), pat(a + 32, 0));
        idle();
        check(int'(conflict_count) == sat(n_conf), "R9 saturated count", int'(conflict_count), sat(n_conf));

        // Exhaustive simultaneous reads over all address pairs.
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 64; j++)
                pair(0, 6'(i), 16'd0, 0, 6'(j), 16'd0);

        // Writes on port 0 mixed with scattered reads on port 1, then full read-back.
        for (int a = 0; a < 64; a++) pair(1, 6'(a), pat(a, 1), 0, 6'((a * 5 + 3) % 64), 16'd0);
        for (int a = 0; a < 32; a++) pair(0, 6'(a), 16'd0, 0, 6'(63 - a), 16'd0);

        // R8: both ports write one address in the same cycle.
        pair(1, 6'd10, 16'hAAAA, 1, 6'd10, 16'h5555);
        tick(1, 0, 6'd10, 16'd0, 0, 0, 6'd0, 16'd0, g0, g1);
        check(p0_rdata == 16'h5555, "R8 last writer", int'(p0_rdata), 16'h5555);

        // R5: port 1 held against three consecutive same-bank requests from port 0.
        idle();
        tick(1, 0, 6'd0, 16'd0, 1, 0, 6'd1, 16'd0, g0, g1);
        check(g0 && !g1, "R4 first conflict p0 wins", int'({g0, g1}), 2);
        tick(1, 0, 6'd8, 16'd0, 1, 0, 6'd1, 16'd0, g0, g1);
        check(g0 && !g1, "R4 second conflict p0 wins", int'({g0, g1}), 2);
        tick(1, 0, 6'd9, 16'd0, 1, 0, 6'd1, 16'd0, g0, g1);
        check(!g0 && g1, "R5 third conflict p1 wins", int'({g0, g1}), 1);
        tick(1, 0, 6'd9, 16'd0, 0, 0, 6'd0, 16'd0, g0, g1);
        check(g0, "R5 p0 served after", int'(g0), 1);

        // R10 / R9: clear, count a few, clear during a conflict.
        conflict_clr = 1'b1;
        idle();
        conflict_clr = 1'b0;
        check(conflict_count == '0, "R10 clear", int'(conflict_count), 0);
        base = n_conf;
        pair(0, 6'd2, 16'd0, 0, 6'd3, 16'd0);
        pair(1, 6'd4, 16'h1234, 0, 6'd13, 16'd0);
        pair(0, 6'd22, 16'd0, 1, 6'd30, 16'hBEEF);
        check(int'(conflict_count) == n_conf - base, "R9 count increments", int'(conflict_count), n_conf - base);
        pair(0, 6'd5, 16'd0, 0, 6'd7, 16'd0);
        pair(0, 6'd5, 16'd0, 0, 6'd7, 16'd0);
        check(int'(conflict_count) == n_conf - base, "R9 no-conflict hold", int'(conflict_count), n_conf - base);
        conflict_clr = 1'b1;
        pair(0, 6'd6, 16'd0, 0, 6'd14, 16'd0);
        conflict_clr = 1'b0;
        check(conflict_count == '0, "R10 clear beats conflict", int'(conflict_count), 0);
        idle();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule